// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters. A receive-clock tick enable sets the sampling rate. A bit period is 1, 16 or 64 ticks, chosen by a rate field. When the period is 16 or 64 ticks, the receiver confirms a start edge at the half-bit point. It then samples each later bit at its middle.

Each character has a start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and one stop bit. The receiver moves each finished character into a single holding register. That register is presented on a valid/ready output stream. The block also keeps sticky parity, framing and overrun flags, plus a live break indication.

The output stream has no back-pressure toward the line, because the line cannot be paused. While a character waits unread, `rd_valid` stays high and `rd_data` holds steady. If another character finishes in that time, it replaces the waiting one and the overrun flag is raised. A transfer happens in any cycle where `rd_valid` and `rd_ready` are both high. When a new character arrives in that same cycle, it is accepted without an overrun.

Top module: `osr_receiver`

## Requirements
- R1: After reset, `rd_valid`, `parity_err`, `framing_err`, `overrun_err` and `break_det` are all low.
- R2: `rate_sel` sets the bit period: 2'b10 gives 16 ticks and 2'b11 gives 64 ticks. Both 2'b01 and 2'b00 give 1 tick. Characters are received correctly at each rate when the period is measured in ticks.
- R3: At rates 16 and 64, a low line level that is high again at the half-bit sample is a false start. It is discarded, and the receiver waits for the next falling level.
- R4: `char_len` 2'b00/01/10/11 selects 5/6/7/8 data bits, received least significant bit first into `rd_data[0]` upward. Bits of `rd_data` above the character length read zero.
- R5: When `par_en` is high, one parity bit follows the data bits. With `par_even` high, the data bits and the parity bit together hold an even number of ones. With `par_even` low, they hold an odd number. A mismatch sets `parity_err`.
- R6: A stop bit sampled low sets `framing_err`. The receiver then accepts no new start until it has sampled the line high.
- R7: A finished character appears on `rd_data` with `rd_valid` high from the clock edge after its stop-bit sample. `rd_valid` then stays high, with the data held, until a cycle where `rd_ready` is high.
- R8: If a character finishes while the previous one is still valid and is not being taken in that cycle, `overrun_err` is set. The new character replaces the old one.
- R9: `parity_err`, `framing_err` and `overrun_err` stay set until an `err_clear` pulse or reset. If a new error occurs in the same cycle as `err_clear`, the flag stays set.
- R10: `break_det` rises once the line has been sampled low for twice the frame length in ticks. The frame length is (start + data + parity + stop) bits times the bit period. `break_det` falls on the first clock with the line high.
- R11: While `rx_enable` is low, a frame in progress is abandoned, no character is delivered, and the break count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Receive-clock enable, one sampling step per high cycle |
| rx_serial | input | 1 | Serial line, idle high |
| rx_enable | input | 1 | Receiver enable command bit |
| rate_sel | input | 2 | Ticks per bit: 00/01 = 1, 10 = 16, 11 = 64 |
| char_len | input | 2 | Data bits: 00 = 5, 01 = 6, 10 = 7, 11 = 8 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| err_clear | input | 1 | Pulse that clears the sticky error flags |
| rd_ready | input | 1 | Consumer accepts the held character |
| rd_valid | output | 1 | A received character is held |
| rd_data | output | 8 | Held character, zero above its length |
| parity_err | output | 1 | Sticky parity mismatch flag |
| framing_err | output | 1 | Sticky low-stop-bit flag |
| overrun_err | output | 1 | Sticky lost-character flag |
| break_det | output | 1 | Line has been low for two frame times |

## Verification
The assertions assume that `rate_sel`, `char_len` and the parity controls stay fixed while a frame or a break count is in progress. They also assume that `tick` and `rx_serial` are synchronous to `clk`. The stimulus changes the frame format only while the line idles high. It raises `tick` for one clock at a time and changes the line level only in the cycle before a tick. A new bit therefore arrives on the first tick of its period, and the mid-bit samples fall inside that bit.

// File: rtl/osr_pkg.sv
package osr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HOLD
  } rx_state_e;

  localparam logic [1:0] RATE_MID  = 2'b10;
  localparam logic [1:0] RATE_HIGH = 2'b11;

  // start + stop + (5 + len) data bits + optional parity
  function automatic logic [3:0] frame_bits(input logic [1:0] len, input logic pen);
    return 4'd7 + {2'b00, len} + {3'b000, pen};
  endfunction

endpackage

// File: rtl/osr_frame_sampler.sv
module osr_frame_sampler #(
  parameter int DATA_W = 8,
  parameter int CW     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic              rx_enable,
  input  logic [CW-1:0]     osr,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_even,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              push_pe,
  output logic              push_fe
);
  import osr_pkg::*;

  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q;
  logic [CW-1:0]     half;
  logic              hit;
  logic [IW-1:0]     last_idx;
  logic              exp_par;

  assign half     = osr >> 1;
  assign hit      = (cnt_q + CNT_ONE) == osr;
  assign last_idx = IW'(4) + IW'(char_len);
  assign exp_par  = par_even ? (^shreg_q) : ~(^shreg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
    end else if (!rx_enable) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else if (tick) begin
      unique case (state_q)
        S_IDLE: if (!rx) begin
          cnt_q   <= '0;
          idx_q   <= '0;
          shreg_q <= '0;
          state_q <= (osr == CNT_ONE) ? S_DATA : S_START;
        end
        S_START: begin
          if ((cnt_q + CNT_ONE) == half) begin
            cnt_q   <= '0;
            state_q <= rx ? S_IDLE : S_DATA;
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        S_DATA: begin
          if (hit) begin
            cnt_q          <= '0;
            shreg_q[idx_q] <= rx;
            if (idx_q == last_idx) state_q <= par_en ? S_PAR : S_STOP;
            else                   idx_q   <= idx_q + IW'(1);
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        S_PAR: begin
          if (hit) begin
            cnt_q   <= '0;
            par_q   <= rx;
            state_q <= S_STOP;
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        S_STOP: begin
          if (hit) begin
            cnt_q   <= '0;
            state_q <= rx ? S_IDLE : S_HOLD;
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        S_HOLD: if (rx) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign push      = rx_enable && tick && hit && (state_q == S_STOP);
  assign push_data = shreg_q;
  assign push_pe   = par_en && (par_q != exp_par);
  assign push_fe   = !rx;

  // R11
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (state_q == S_IDLE));

  // R6
  hold_until_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HOLD && !rx) |=> (state_q == S_HOLD || !rx_enable));

endmodule

// File: rtl/osr_break_watch.sv
module osr_break_watch #(
  parameter int CW = 7,
  parameter int BW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  input  logic          rx_enable,
  input  logic [CW-1:0] osr,
  input  logic [1:0]    char_len,
  input  logic          par_en,
  output logic          brk
);
  import osr_pkg::*;

  logic [BW-1:0] thr;
  logic [BW-1:0] low_cnt_q;
  logic          brk_q;

  assign thr = (BW'(frame_bits(char_len, par_en)) * BW'(osr)) << 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      brk_q     <= 1'b0;
    end else if (!rx_enable || rx) begin
      low_cnt_q <= '0;
      brk_q     <= 1'b0;
    end else if (tick && !brk_q) begin
      low_cnt_q <= low_cnt_q + BW'(1);
      if ((low_cnt_q + BW'(1)) == thr) brk_q <= 1'b1;
    end
  end

  assign brk = brk_q;

  // R10
  break_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx |=> !brk_q);

  // R10
  break_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_q) |-> ($past(!rx) && $past(tick)));

endmodule

// File: rtl/osr_rx_buffer.sv
module osr_rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_pe,
  input  logic              push_fe,
  input  logic              rd_ready,
  input  logic              err_clear,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              pe_flag,
  output logic              fe_flag,
  output logic              ovr_flag
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              pe_q, fe_q, ovr_q;
  logic              pop;

  assign pop = valid_q && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (push) begin
        data_q  <= push_data;
        valid_q <= 1'b1;
      end else if (pop) begin
        valid_q <= 1'b0;
      end
      if (push && push_pe)               pe_q  <= 1'b1;
      else if (err_clear)                pe_q  <= 1'b0;
      if (push && push_fe)               fe_q  <= 1'b1;
      else if (err_clear)                fe_q  <= 1'b0;
      if (push && valid_q && !rd_ready)  ovr_q <= 1'b1;
      else if (err_clear)                ovr_q <= 1'b0;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;
  assign pe_flag  = pe_q;
  assign fe_flag  = fe_q;
  assign ovr_flag = ovr_q;

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rd_ready && !push) |=> (valid_q && $stable(data_q)));

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(valid_q));

  // R9
  flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !push) |=> (!pe_q && !fe_q && !ovr_q));

endmodule

// File: rtl/osr_receiver.sv
module osr_receiver #(
  parameter int DATA_W   = 8,
  parameter int OSR_MID  = 16,
  parameter int OSR_HIGH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_serial,
  input  logic              rx_enable,
  input  logic [1:0]        rate_sel,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              err_clear,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              parity_err,
  output logic              framing_err,
  output logic              overrun_err,
  output logic              break_det
);
  import osr_pkg::*;

  localparam int CW = $clog2(OSR_HIGH) + 1;
  localparam int BW = $clog2(2 * (DATA_W + 3) * OSR_HIGH + 1);

  logic [CW-1:0]     osr;
  logic              push, push_pe, push_fe;
  logic [DATA_W-1:0] push_data;

  always_comb begin
    unique case (rate_sel)
      RATE_MID:  osr = CW'(OSR_MID);
      RATE_HIGH: osr = CW'(OSR_HIGH);
      default:   osr = CW'(1);
    endcase
  end

  osr_frame_sampler #(.DATA_W(DATA_W), .CW(CW)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_serial),
    .rx_enable(rx_enable), .osr(osr), .char_len(char_len),
    .par_en(par_en), .par_even(par_even),
    .push(push), .push_data(push_data), .push_pe(push_pe), .push_fe(push_fe)
  );

  osr_break_watch #(.CW(CW), .BW(BW)) u_break (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_serial),
    .rx_enable(rx_enable), .osr(osr), .char_len(char_len),
    .par_en(par_en), .brk(break_det)
  );

  osr_rx_buffer #(.DATA_W(DATA_W)) u_buffer (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .push_pe(push_pe), .push_fe(push_fe), .rd_ready(rd_ready),
    .err_clear(err_clear), .rd_valid(rd_valid), .rd_data(rd_data),
    .pe_flag(parity_err), .fe_flag(framing_err), .ovr_flag(overrun_err)
  );

  // R11
  no_push_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && !rd_valid && !rd_ready) |=> !rd_valid);

endmodule

// File: tb/osr_receiver_bench.sv
module osr_receiver_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx_serial = 1'b1;
  logic       rx_enable = 1'b1;
  logic [1:0] rate_sel = 2'b10;
  logic [1:0] char_len = 2'b11;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       err_clear = 1'b0;
  logic       rd_ready = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       parity_err, framing_err, overrun_err, break_det;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osr_receiver u_osr_receiver (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_serial(rx_serial),
    .rx_enable(rx_enable), .rate_sel(rate_sel), .char_len(char_len),
    .par_en(par_en), .par_even(par_even), .err_clear(err_clear),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .parity_err(parity_err), .framing_err(framing_err),
    .overrun_err(overrun_err), .break_det(break_det)
  );

  // {rate, len, pen, even, stop, flip, data, exp_data, exp_pe, exp_fe}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {2'b10, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b0},
    {2'b10, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b0},
    {2'b10, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 8'hD5, 8'h55, 1'b0, 1'b0},
    {2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h35, 8'h15, 1'b0, 1'b0},
    {2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 8'h2A, 8'h2A, 1'b0, 1'b0},
    {2'b10, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'h81, 8'h81, 1'b1, 1'b0},
    {2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h7E, 8'h7E, 1'b0, 1'b1},
    {2'b01, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b0},
    {2'b11, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0},
    {2'b00, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h5A, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  function automatic int osr_of(input logic [1:0] sel);
    return (sel == 2'b10) ? 16 : (sel == 2'b11) ? 64 : 1;
  endfunction

  task automatic send_bit(input logic b, input int n);
    rx_serial = b;
    repeat (n) do_tick();
  endtask

  task automatic send_frame(input logic [1:0] sel, input logic [1:0] len,
                            input logic pen, input logic ev, input logic stopv,
                            input logic flip, input logic [7:0] d);
    int osr = osr_of(sel);
    int nb = 5 + int'(len);
    logic p = 1'b0;
    rate_sel = sel; char_len = len; par_en = pen; par_even = ev;
    send_bit(1'b0, osr);
    for (int i = 0; i < nb; i++) begin
      send_bit(d[i], osr);
      p ^= d[i];
    end
    if (pen) send_bit((ev ? p : ~p) ^ flip, osr);
    send_bit(stopv, osr);
    send_bit(1'b1, osr);
  endtask

  task automatic pop();
    @(negedge clk) rd_ready = 1'b1;
    @(negedge clk) rd_ready = 1'b0;
  endtask

  task automatic clear_errs();
    @(negedge clk) err_clear = 1'b1;
    @(negedge clk) err_clear = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!rd_valid, "R1 rd_valid", rd_valid, 0);
    check({parity_err, framing_err, overrun_err, break_det} == 4'b0, "R1 flags",
          {parity_err, framing_err, overrun_err, break_det}, 0);
    send_bit(1'b1, 4);

    // Vector table: R2 rates, R4 lengths, R5 parity, R6 framing, R7 delivery
    for (int v = 0; v < NV; v++) begin
      logic [25:0] e = VEC[v];
      send_frame(e[25:24], e[23:22], e[21], e[20], e[19], e[18], e[17:10]);
      check(rd_valid, "R7 valid", rd_valid, 1);
      check(rd_data == e[9:2], "R2/R4 data", rd_data, e[9:2]);
      check(parity_err == e[1], "R5 parity", parity_err, e[1]);
      check(framing_err == e[0], "R6 framing", framing_err, e[0]);
      pop();
      check(!rd_valid, "R7 handshake", rd_valid, 0);
      clear_errs();
      check(!parity_err && !framing_err, "R9 clear",
            {parity_err, framing_err}, 0);
    end

    // R3 false start at x16
    rate_sel = 2'b10; char_len = 2'b11; par_en = 1'b0;
    send_bit(1'b0, 4);
    send_bit(1'b1, 40);
    check(!rd_valid, "R3 false start", rd_valid, 0);
    send_frame(2'b10, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC3);
    check(rd_valid && rd_data == 8'hC3, "R3 recovery", rd_data, 8'hC3);

    // R8 overrun: second character while first still held
    send_frame(2'b10, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h96);
    check(overrun_err, "R8 flag", overrun_err, 1);
    check(rd_data == 8'h96, "R8 replace", rd_data, 8'h96);
    pop();
    send_bit(1'b1, 2);
    // R9 sticky until cleared
    check(overrun_err, "R9 sticky", overrun_err, 1);
    clear_errs();
    check(!overrun_err, "R9 clear ovr", overrun_err, 0);

    // R11 disabled receiver delivers nothing
    rx_enable = 1'b0;
    send_frame(2'b10, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h11);
    check(!rd_valid, "R11 disabled", rd_valid, 0);
    rx_serial = 1'b0;
    repeat (400) do_tick();
    check(!break_det, "R11 break held", break_det, 0);
    rx_serial = 1'b1;
    @(negedge clk) rx_enable = 1'b1;
    send_bit(1'b1, 2);

    // R10 break at x1, 8 bits, no parity: 2*10 = 20 ticks
    rate_sel = 2'b01; char_len = 2'b11; par_en = 1'b0;
    send_bit(1'b0, 19);
    check(!break_det, "R10 below threshold", break_det, 0);
    do_tick();
    check(break_det, "R10 set", break_det, 1);
    // R6 one zero character with framing error, no restart while low
    check(rd_valid && rd_data == 8'h00, "R6 break char", rd_data, 0);
    check(framing_err && !overrun_err, "R6 hold",
          {framing_err, overrun_err}, 2);
    rx_serial = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!break_det, "R10 clear", break_det, 0);
    pop();
    clear_errs();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule